// File: doc/BRIEF.md
# Asynchronous External Memory Bus Controller

This block connects an internal request port to slow external parallel parts such as SRAMs or display controllers. Each internal request carries a byte address, a size (byte, half-word or word) and a direction. The controller splits the request into as many external bus cycles as the selected device needs. Each external cycle has setup, strobe and hold phases, and a multiplexed device also gets a one-clock address-latch phase in front of them. Two chip selects are provided. Each one has its own device width, bus mode and phase lengths.

A device is either 8 bits wide or 16 bits wide. An 8-bit device may have a separate address bus or share address and data on one bus. A 16-bit device must share the bus. During the latch phase, a 16-bit device receives its address shifted right by one, so it sees a half-word index. An extended address output carries the upper address byte, so that an 8-bit part can reach a 24-bit space.

The request side is a valid/ready handshake. `req_ready_o` is high only while no transfer is in progress, and a request is taken on any clock where valid and ready are both high. The request fields need only be stable on that clock. The response side has no back-pressure. `rsp_valid_o` pulses for exactly one clock, and the consumer must take `rsp_rdata_o` and `rsp_err_o` in that clock. The configuration inputs must stay constant while a transfer is in progress.

Top module: `xmem_ctrl`

## Requirements
- R1: `req_ready_o` is high after reset and low on every clock in which an external cycle is in progress. A completed transfer gives a single-clock `rsp_valid_o` in the clock after its last hold clock.
- R2: With all phase counts at zero and a non-multiplexed device, a write holds its chip select low for 3 clocks with the write strobe low for the middle 1. A read holds its chip select low for 4 clocks with the read strobe low for the last 2 before hold.
- R3: For a chip select with counts S, W and H, setup lasts S+1 clocks. The strobe lasts W+1 clocks on a write and W+2 clocks on a read. Hold lasts H+1 clocks. Counts programmed for one chip select do not change the cycles of the other.
- R4: The number of external cycles follows the device width. An 8-bit device takes 1, 2 or 4 cycles for a byte, half-word or word. A 16-bit device takes 1, 1 or 2 cycles for the same sizes. Cycles go from the lowest address upward, and the least significant data goes first (little-endian).
- R5: In multiplexed mode, `ale_o` is high for exactly one clock before each setup phase. During that clock `xd_o` carries the byte address for an 8-bit device, or the byte address shifted right by one for a 16-bit device.
- R6: The following requests are refused: size code 3; a 16-bit device configured without multiplexing; a half-word or word request to a 16-bit device at an odd address. A refused request drives no chip select, and it gives `rsp_valid_o` with `rsp_err_o` high in the clock after it is accepted.
- R7: Bit 24 of `req_addr_i` selects the chip select, and only that `cs_n_o` bit (active low) goes low during the transfer.
- R8: `xa_hi_o` carries bits 23:16 of the current external byte address throughout the cycle.
- R9: Read data is sampled from `xd_i` on the last clock of the read strobe. A byte read from a 16-bit device takes the upper lane `xd_i[15:8]` at an odd address and the lower lane at an even address. The byte is returned in `rsp_rdata_o[7:0]`.
- R10: On a write, `xd_oe_o` is high on every clock from the first latch or setup clock through the last hold clock. On a read, it is high only during the latch clock, and never while `oe_n_o` is low.
- R11: Byte enables `be_n_o` are active low, with bit 0 for lane `[7:0]` and bit 1 for lane `[15:8]`. An 8-bit device uses 2'b10. A 16-bit half-word or word access uses 2'b00. A 16-bit byte access uses 2'b01 at an odd address and 2'b10 at an even address. The write byte is placed on both lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_addr_i | input | 25 | Bit 24 selects the chip select; bits 23:0 are the byte address |
| req_size_i | input | 2 | 0 byte, 1 half-word, 2 word, 3 illegal |
| req_write_i | input | 1 | 1 write, 0 read |
| req_wdata_i | input | 32 | Write data, right aligned |
| rsp_valid_o | output | 1 | One-clock completion pulse |
| rsp_err_o | output | 1 | Request was refused |
| rsp_rdata_o | output | 32 | Read data, right aligned |
| cfg_wide_i | input | 2 | Per chip select: device is 16 bits wide |
| cfg_mux_i | input | 2 | Per chip select: address/data multiplexed |
| cfg_setup_i | input | 8 | Per chip select setup count, 4 bits each |
| cfg_strobe_i | input | 8 | Per chip select strobe count, 4 bits each |
| cfg_hold_i | input | 8 | Per chip select hold count, 4 bits each |
| cs_n_o | output | 2 | Chip selects, active low |
| ale_o | output | 1 | Address latch enable |
| we_n_o | output | 1 | Write strobe, active low |
| oe_n_o | output | 1 | Read strobe, active low |
| be_n_o | output | 2 | Byte lane enables, active low |
| xa_hi_o | output | 8 | Extended address bits 23:16 |
| xaddr_o | output | 16 | Low byte address for non-multiplexed devices |
| xd_o | output | 16 | Shared bus output value |
| xd_i | input | 16 | Shared bus input value |
| xd_oe_o | output | 1 | Drive enable for the shared bus |

## Verification
The hardest case to reach is a word transfer on the multiplexed 16-bit chip select. The latched half-word index has to advance between the two cycles while the read data is assembled from the correct lane in each one. The bench gives each chip select a byte-array device model. This model latches `xd_o` on each latch clock and serves reads from that latched index, so a wrong shift or a wrong order shows up as wrong memory contents or wrong returned data. A separate run programs long phase counts on one chip select and then issues a transfer on the other, to show that the counts of the two do not mix.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALE,
    PH_SETUP,
    PH_STRB,
    PH_HOLD
  } phase_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_t;
endpackage

// File: rtl/xmem_decode.sv
module xmem_decode
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NCS    = 2,
  parameter int CS_W   = 1
) (
  input  logic [ADDR_W+CS_W-1:0] addr_i,
  input  logic [1:0]             size_i,
  input  logic [NCS-1:0]         cfg_wide_i,
  input  logic [NCS-1:0]         cfg_mux_i,
  output logic [CS_W-1:0]        cs_o,
  output logic                   wide_o,
  output logic                   mux_o,
  output logic                   err_o,
  output logic [1:0]             last_beat_o
);
  logic cs_ok;

  always_comb begin
    cs_o   = addr_i[ADDR_W +: CS_W];
    cs_ok  = (int'(cs_o) < NCS);
    wide_o = 1'b0;
    mux_o  = 1'b0;
    for (int i = 0; i < NCS; i++) begin
      if (cs_o == CS_W'(i)) begin
        wide_o = cfg_wide_i[i];
        mux_o  = cfg_mux_i[i];
      end
    end
    err_o = !cs_ok || (size_i == SZ_BAD) || (wide_o && !mux_o) ||
            (wide_o && (size_i != SZ_BYTE) && addr_i[0]);
    if (wide_o)
      last_beat_o = (size_i == SZ_WORD) ? 2'd1 : 2'd0;
    else
      case (size_i)
        SZ_BYTE: last_beat_o = 2'd0;
        SZ_HALF: last_beat_o = 2'd1;
        default: last_beat_o = 2'd3;
      endcase
  end
endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mux_i,
  input  logic          rd_i,
  input  logic [CW-1:0] setup_i,
  input  logic [CW-1:0] strobe_i,
  input  logic [CW-1:0] hold_i,
  input  logic [1:0]    last_beat_i,
  output phase_t        phase_o,
  output logic [1:0]    beat_o,
  output logic          cap_o,
  output logic          done_o
);
  logic [CW:0] cnt;
  logic        setup_end, strb_end, hold_end;
  phase_t      first_ph;

  assign setup_end = (cnt == {1'b0, setup_i});
  assign strb_end  = (cnt == ({1'b0, strobe_i} + {{CW{1'b0}}, rd_i}));
  assign hold_end  = (cnt == {1'b0, hold_i});
  assign first_ph  = mux_i ? PH_ALE : PH_SETUP;
  assign cap_o     = (phase_o == PH_STRB) && strb_end && rd_i;
  assign done_o    = (phase_o == PH_HOLD) && hold_end && (beat_o == last_beat_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o <= PH_IDLE;
      cnt     <= '0;
      beat_o  <= '0;
    end else begin
      case (phase_o)
        PH_IDLE: if (start_i) begin
          phase_o <= first_ph;
          cnt     <= '0;
          beat_o  <= '0;
        end
        PH_ALE: begin
          phase_o <= PH_SETUP;
          cnt     <= '0;
        end
        PH_SETUP: if (setup_end) begin
          phase_o <= PH_STRB;
          cnt     <= '0;
        end else cnt <= cnt + 1'b1;
        PH_STRB: if (strb_end) begin
          phase_o <= PH_HOLD;
          cnt     <= '0;
        end else cnt <= cnt + 1'b1;
        PH_HOLD: if (hold_end) begin
          cnt <= '0;
          if (beat_o == last_beat_i) phase_o <= PH_IDLE;
          else begin
            beat_o  <= beat_o + 1'b1;
            phase_o <= first_ph;
          end
        end else cnt <= cnt + 1'b1;
        default: phase_o <= PH_IDLE;
      endcase
    end
  end

  // R5
  ale_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_ALE) |=> (phase_o == PH_SETUP));

  // R3
  strb_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_o == PH_STRB) |-> ($past(phase_o) == PH_SETUP));
endmodule

// File: rtl/xmem_path.sv
module xmem_path
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        size_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              wide_i,
  input  logic [1:0]        beat_i,
  input  phase_t            phase_i,
  input  logic              cap_i,
  input  logic [15:0]       xd_i,
  output logic [15:0]       xaddr_o,
  output logic [ADDR_W-17:0] xa_hi_o,
  output logic [15:0]       xd_o,
  output logic [1:0]        be_n_o,
  output logic [DW-1:0]     rdata_o
);
  logic [ADDR_W-1:0] base_q, offs, beat_addr;
  logic [1:0]        size_q;
  logic [DW-1:0]     wdata_q, wsh8, wsh16;
  logic [15:0]       wr_lane;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      rdata_o <= '0;
    end else if (load_i) begin
      base_q  <= base_i;
      size_q  <= size_i;
      wdata_q <= wdata_i;
      rdata_o <= '0;
    end else if (cap_i) begin
      if (!wide_i)
        rdata_o[{beat_i, 3'b000} +: 8] <= xd_i[7:0];
      else if (size_q == SZ_BYTE)
        rdata_o[7:0] <= base_q[0] ? xd_i[15:8] : xd_i[7:0];
      else
        rdata_o[{beat_i[0], 4'b0000} +: 16] <= xd_i;
    end
  end

  always_comb begin
    offs      = wide_i ? {{(ADDR_W-3){1'b0}}, beat_i, 1'b0} : {{(ADDR_W-2){1'b0}}, beat_i};
    beat_addr = base_q + offs;
    wsh8      = wdata_q >> {beat_i, 3'b000};
    wsh16     = wdata_q >> {beat_i, 4'b0000};
    if (!wide_i)                 wr_lane = {8'h00, wsh8[7:0]};
    else if (size_q == SZ_BYTE)  wr_lane = {wdata_q[7:0], wdata_q[7:0]};
    else                         wr_lane = wsh16[15:0];
    if (phase_i == PH_IDLE)      be_n_o = 2'b11;
    else if (!wide_i)            be_n_o = 2'b10;
    else if (size_q == SZ_BYTE)  be_n_o = base_q[0] ? 2'b01 : 2'b10;
    else                         be_n_o = 2'b00;
    xaddr_o = beat_addr[15:0];
    xa_hi_o = beat_addr[ADDR_W-1:16];
    if (phase_i == PH_ALE) xd_o = wide_i ? beat_addr[16:1] : beat_addr[15:0];
    else                   xd_o = wr_lane;
  end

  // R9
  cap_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |-> (phase_i == PH_STRB));
endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int NCS    = 2,
  parameter int CW     = 4,
  localparam int CS_W  = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int IW    = ADDR_W + CS_W,
  localparam int XW    = ADDR_W - 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [IW-1:0]     req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_write_i,
  input  logic [31:0]       req_wdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_err_o,
  output logic [31:0]       rsp_rdata_o,
  input  logic [NCS-1:0]    cfg_wide_i,
  input  logic [NCS-1:0]    cfg_mux_i,
  input  logic [NCS*CW-1:0] cfg_setup_i,
  input  logic [NCS*CW-1:0] cfg_strobe_i,
  input  logic [NCS*CW-1:0] cfg_hold_i,
  output logic [NCS-1:0]    cs_n_o,
  output logic              ale_o,
  output logic              we_n_o,
  output logic              oe_n_o,
  output logic [1:0]        be_n_o,
  output logic [XW-1:0]     xa_hi_o,
  output logic [15:0]       xaddr_o,
  output logic [15:0]       xd_o,
  input  logic [15:0]       xd_i,
  output logic              xd_oe_o
);
  logic [CS_W-1:0] dec_cs, cs_q;
  logic            dec_wide, dec_mux, dec_err;
  logic [1:0]      dec_last, last_q, beat;
  logic            wide_q, mux_q, wr_q, accept, cap, done;
  logic [CW-1:0]   setup_sel, strobe_sel, hold_sel;
  phase_t          phase;

  assign req_ready_o = (phase == PH_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  xmem_decode #(.ADDR_W(ADDR_W), .NCS(NCS), .CS_W(CS_W)) u_dec (
    .addr_i(req_addr_i), .size_i(req_size_i),
    .cfg_wide_i(cfg_wide_i), .cfg_mux_i(cfg_mux_i),
    .cs_o(dec_cs), .wide_o(dec_wide), .mux_o(dec_mux),
    .err_o(dec_err), .last_beat_o(dec_last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '0; wide_q <= 1'b0; mux_q <= 1'b0; wr_q <= 1'b0; last_q <= '0;
      rsp_valid_o <= 1'b0; rsp_err_o <= 1'b0;
    end else begin
      if (accept) begin
        cs_q <= dec_cs; wide_q <= dec_wide; mux_q <= dec_mux;
        wr_q <= req_write_i; last_q <= dec_last;
      end
      rsp_valid_o <= done || (accept && dec_err);
      rsp_err_o   <= accept && dec_err;
    end
  end

  assign setup_sel  = cfg_setup_i[cs_q*CW +: CW];
  assign strobe_sel = cfg_strobe_i[cs_q*CW +: CW];
  assign hold_sel   = cfg_hold_i[cs_q*CW +: CW];

  xmem_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(accept && !dec_err),
    .mux_i(accept ? dec_mux : mux_q), .rd_i(!wr_q),
    .setup_i(setup_sel), .strobe_i(strobe_sel), .hold_i(hold_sel),
    .last_beat_i(last_q), .phase_o(phase), .beat_o(beat),
    .cap_o(cap), .done_o(done));

  xmem_path #(.ADDR_W(ADDR_W), .DW(32)) u_path (
    .clk(clk), .rst_n(rst_n), .load_i(accept),
    .base_i(req_addr_i[ADDR_W-1:0]), .size_i(req_size_i),
    .wdata_i(req_wdata_i), .wide_i(wide_q), .beat_i(beat),
    .phase_i(phase), .cap_i(cap), .xd_i(xd_i),
    .xaddr_o(xaddr_o), .xa_hi_o(xa_hi_o), .xd_o(xd_o),
    .be_n_o(be_n_o), .rdata_o(rsp_rdata_o));

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_n_o[g] = !((phase != PH_IDLE) && (cs_q == CS_W'(g)));
  end

  assign ale_o   = (phase == PH_ALE);
  assign we_n_o  = !((phase == PH_STRB) && wr_q);
  assign oe_n_o  = !((phase == PH_STRB) && !wr_q);
  assign xd_oe_o = (phase == PH_ALE) || (wr_q && (phase != PH_IDLE));

  // R6
  err_no_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_err) |=> (rsp_valid_o && rsp_err_o && (&cs_n_o)));

  // R1
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !accept) |=> !rsp_valid_o);

  // R7
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n_o));

  // R10
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_o |-> !xd_oe_o);

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_o && !oe_n_o));
endmodule

// File: tb/xmem_ctrl_bench.sv
`timescale 1ns/1ps
module xmem_ctrl_bench;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic        req_ready, rsp_valid, rsp_err, ale, we_n, oe_n, xd_oe;
  logic [24:0] req_addr = '0;
  logic [1:0]  req_size = '0, cs_n, be_n;
  logic [31:0] req_wdata = '0, rsp_rdata;
  logic [1:0]  cfg_wide = '0, cfg_mux = '0;
  logic [7:0]  cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0, xa_hi;
  logic [15:0] xaddr, xd_o, xd_i;

  xmem_ctrl u_xmem_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_write_i(req_write),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
    .rsp_rdata_o(rsp_rdata), .cfg_wide_i(cfg_wide), .cfg_mux_i(cfg_mux),
    .cfg_setup_i(cfg_setup), .cfg_strobe_i(cfg_strobe), .cfg_hold_i(cfg_hold),
    .cs_n_o(cs_n), .ale_o(ale), .we_n_o(we_n), .oe_n_o(oe_n), .be_n_o(be_n),
    .xa_hi_o(xa_hi), .xaddr_o(xaddr), .xd_o(xd_o), .xd_i(xd_i), .xd_oe_o(xd_oe));

  // device model
  logic [7:0]  mem [0:255];
  logic        tb_wide = 0, tb_mux = 0;
  logic [15:0] lat = '0, dev_a;
  assign dev_a = tb_mux ? (tb_wide ? {lat[14:0], 1'b0} : lat) : xaddr;
  assign xd_i  = tb_wide ? {mem[dev_a[7:0] | 8'h01], mem[dev_a[7:0] & 8'hFE]}
                         : {8'h00, mem[dev_a[7:0]]};

  int total = 0, bad = 0;
  int r_cs, r_we, r_oe, r_ale, r_nb, r_rdylow, r_drv, r_oebad, r_cyc;
  logic [15:0] r_ba [0:3];
  logic [15:0] r_ala [0:3];
  logic [1:0]  r_csand, r_be;
  logic [7:0]  r_hi;
  logic [31:0] r_rdata;
  logic        r_err, r_after;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [24:0] a, input logic [1:0] sz, input logic wr,
                      input logic [31:0] wd);
    logic pwe, poe;
    r_cs = 0; r_we = 0; r_oe = 0; r_ale = 0; r_nb = 0; r_rdylow = 0; r_drv = 0;
    r_oebad = 0; r_cyc = 0; r_csand = 2'b11; r_be = 2'b11; r_hi = 0;
    r_rdata = 0; r_err = 0; pwe = 1; poe = 1;
    for (int k = 0; k < 4; k++) begin r_ba[k] = 0; r_ala[k] = 0; end
    @(negedge clk);
    req_valid = 1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
    @(posedge clk);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (i == 0) req_valid = 0;
      r_cyc++;
      if (cs_n != 2'b11) begin
        r_cs++; r_csand &= cs_n;
        if (!req_ready) r_rdylow++;
        if (xd_oe) r_drv++;
      end
      if (ale) begin
        if (r_ale < 4) r_ala[r_ale] = xd_o;
        r_ale++; lat = xd_o;
      end
      #0.1;
      if (!we_n) begin
        r_we++;
        if (pwe && r_nb < 4) begin
          r_ba[r_nb] = dev_a; r_be = be_n; r_hi = xa_hi; r_nb++;
          if (!tb_wide) mem[dev_a[7:0]] = xd_o[7:0];
          else begin
            if (!be_n[0]) mem[dev_a[7:0] & 8'hFE] = xd_o[7:0];
            if (!be_n[1]) mem[dev_a[7:0] | 8'h01] = xd_o[15:8];
          end
        end
      end
      if (!oe_n) begin
        r_oe++;
        if (xd_oe) r_oebad++;
        if (poe && r_nb < 4) begin r_ba[r_nb] = dev_a; r_be = be_n; r_hi = xa_hi; r_nb++; end
      end
      pwe = we_n; poe = oe_n;
      if (rsp_valid) begin r_rdata = rsp_rdata; r_err = rsp_err; break; end
    end
    @(negedge clk);
    r_after = rsp_valid;
  endtask

  task automatic t_reset;
    chk("R1 ready after reset", {31'b0, req_ready}, 1);
    chk("R7 cs idle after reset", {30'b0, cs_n}, 2'b11);
    chk("R1 no rsp after reset", {31'b0, rsp_valid}, 0);
  endtask

  task automatic t_min_write;
    tb_wide = 0; tb_mux = 0;
    xfer({1'b0, 24'h12_0034}, 2'd0, 1, 32'h5A);
    chk("R2 write cs clocks", r_cs, 3);
    chk("R2 write strobe clocks", r_we, 1);
    chk("R7 cs0 only", {30'b0, r_csand}, 2'b10);
    chk("R8 extended address", {24'b0, r_hi}, 8'h12);
    chk("R11 narrow byte enables", {30'b0, r_be}, 2'b10);
    chk("R4 byte stored", {24'b0, mem[8'h34]}, 8'h5A);
    chk("R1 ready low during cycle", r_rdylow, 3);
    chk("R1 rsp single clock", {31'b0, r_after}, 0);
  endtask

  task automatic t_min_read;
    tb_wide = 0; tb_mux = 0; mem[8'h40] = 8'hC3;
    xfer(25'h40, 2'd0, 0, 0);
    chk("R2 read cs clocks", r_cs, 4);
    chk("R2 read strobe clocks", r_oe, 2);
    chk("R9 read byte", r_rdata, 32'hC3);
    chk("R6 no error on legal read", {31'b0, r_err}, 0);
  endtask

  task automatic t_word_narrow;
    tb_wide = 0; tb_mux = 0;
    xfer(25'h10, 2'd2, 1, 32'h44332211);
    chk("R4 four cycles", r_nb, 4);
    chk("R4 first address", {16'b0, r_ba[0]}, 16'h10);
    chk("R4 last address", {16'b0, r_ba[3]}, 16'h13);
    chk("R4 low byte first", {24'b0, mem[8'h10]}, 8'h11);
    chk("R4 high byte last", {24'b0, mem[8'h13]}, 8'h44);
    chk("R4 word write clocks", r_cs, 12);
    xfer(25'h10, 2'd2, 0, 0);
    chk("R4 word read assembly", r_rdata, 32'h44332211);
    xfer(25'h11, 2'd1, 0, 0);
    chk("R4 unaligned half on 8-bit", r_rdata, 32'h3322);
  endtask

  task automatic t_mux16;
    cfg_wide[1] = 1; cfg_mux[1] = 1; tb_wide = 1; tb_mux = 1;
    xfer({1'b1, 24'h20}, 2'd2, 1, 32'hDDCCBBAA);
    chk("R5 latch pulses", r_ale, 2);
    chk("R5 shifted address beat0", {16'b0, r_ala[0]}, 16'h10);
    chk("R5 shifted address beat1", {16'b0, r_ala[1]}, 16'h11);
    chk("R7 cs1 only", {30'b0, r_csand}, 2'b01);
    chk("R4 wide low half", {16'b0, mem[8'h21], mem[8'h20]}, 16'hBBAA);
    chk("R4 wide high half", {16'b0, mem[8'h23], mem[8'h22]}, 16'hDDCC);
    chk("R11 wide word enables", {30'b0, r_be}, 2'b00);
    chk("R10 write drive every clock", r_drv, 8);
    xfer({1'b1, 24'h20}, 2'd2, 0, 0);
    chk("R9 wide word read", r_rdata, 32'hDDCCBBAA);
    chk("R10 read drive only in latch", r_drv, 2);
    chk("R10 no drive under read strobe", r_oebad, 0);
    chk("R3 wide read cs clocks", r_cs, 10);
  endtask

  task automatic t_wide_byte;
    tb_wide = 1; tb_mux = 1; mem[8'h30] = 8'h99;
    xfer({1'b1, 24'h31}, 2'd0, 1, 32'h77);
    chk("R11 odd byte enables", {30'b0, r_be}, 2'b01);
    chk("R11 upper lane written", {24'b0, mem[8'h31]}, 8'h77);
    chk("R11 lower lane untouched", {24'b0, mem[8'h30]}, 8'h99);
    chk("R5 odd byte latch address", {16'b0, r_ala[0]}, 16'h18);
    xfer({1'b1, 24'h31}, 2'd0, 0, 0);
    chk("R9 upper lane read", r_rdata, 32'h77);
    xfer({1'b1, 24'h30}, 2'd0, 0, 0);
    chk("R9 lower lane read", r_rdata, 32'h99);
  endtask

  task automatic t_timing;
    cfg_setup[3:0] = 4'd2; cfg_strobe[3:0] = 4'd3; cfg_hold[3:0] = 4'd1;
    tb_wide = 0; tb_mux = 0;
    xfer(25'h50, 2'd0, 1, 32'h3C);
    chk("R3 long write cs clocks", r_cs, 9);
    chk("R3 long write strobe", r_we, 4);
    xfer(25'h50, 2'd0, 0, 0);
    chk("R3 long read cs clocks", r_cs, 10);
    chk("R3 long read strobe", r_oe, 5);
    chk("R3 long read data", r_rdata, 32'h3C);
    tb_wide = 1; tb_mux = 1;
    xfer({1'b1, 24'h60}, 2'd1, 1, 32'h1234);
    chk("R3 other cs unaffected", r_cs, 4);
    cfg_setup = '0; cfg_strobe = '0; cfg_hold = '0;
  endtask

  task automatic t_mux8;
    cfg_mux[0] = 1; tb_wide = 0; tb_mux = 1;
    xfer(25'h0155, 2'd0, 1, 32'h66);
    chk("R5 unshifted byte address", {16'b0, r_ala[0]}, 16'h0155);
    chk("R5 narrow mux cs clocks", r_cs, 4);
    chk("R5 narrow mux data", {24'b0, mem[8'h55]}, 8'h66);
    cfg_mux[0] = 0;
  endtask

  task automatic t_errors;
    xfer({1'b1, 24'h33}, 2'd1, 0, 0);
    chk("R6 odd half on wide err", {31'b0, r_err}, 1);
    chk("R6 odd half no cycle", r_cs, 0);
    chk("R6 response next clock", r_cyc, 1);
    xfer({1'b1, 24'h35}, 2'd2, 1, 32'hFFFF_FFFF);
    chk("R6 odd word on wide err", {31'b0, r_err}, 1);
    cfg_wide[0] = 1;
    xfer(25'h8, 2'd0, 0, 0);
    chk("R6 wide without mux err", {31'b0, r_err}, 1);
    chk("R6 wide without mux no cycle", r_cs, 0);
    cfg_wide[0] = 0;
    xfer(25'h8, 2'd3, 0, 0);
    chk("R6 bad size err", {31'b0, r_err}, 1);
    chk("R1 error rsp single clock", {31'b0, r_after}, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_min_write();
    t_min_read();
    t_word_narrow();
    t_mux16();
    t_wide_byte();
    t_timing();
    t_mux8();
    t_errors();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule